// File: doc/BRIEF.md
# Grid Max-Min Lockstep Sequencer

This block finds the largest and the smallest of a set of unsigned values in a single pass. The values are held in a four-by-four grid of small reduction clusters, with four leaf registers in each cluster. The data set fills every leaf of the nine clusters outside the top row and the left column, which gives 36 values. Software writes the values one at a time through an indexed load port and then pulses start. A fixed sequence of steps then runs in lockstep across all clusters. Each step is a tree-reduction level inside every cluster, a copy of a cluster result into the spare register of that cluster's first leaf, or a transpose-style move of those spare registers between clusters.

The empty top row and left column are seeded with sentinels: zero in the first leaf of each left-column cluster, and all-ones in the first leaf of each other top-row cluster. After three phases, partial maxima have moved left and then up into the corner cluster. Partial minima have moved up and then left into the same corner. The maximum ends in the corner cluster's first leaf and the minimum in that leaf's spare register. Both are presented on the outputs together with a done flag. Each inter-cluster move takes one cycle.

Top module: `mm_grid_top`

## Requirements
- R1: After reset, done_o is 0, max_o is 0 and min_o is 0.
- R2: While idle, a write with load_en_i high stores load_val_i in the data leaf at index ((r-1)·(N-1)+(c-1))·N+k. Here r and c are the zero-based cluster row and column, both at least 1, and k is the zero-based leaf. Indices of N·(N-1)² or above are ignored.
- R3: The sentinel seeds that start places in the empty row and column never become a result. A data set of all-equal values returns that value as both maximum and minimum.
- R4: When done_o rises, max_o equals the largest of the N·(N-1)² loaded values.
- R5: When done_o rises, min_o equals the smallest of the loaded values.
- R6: A start accepted while idle makes done_o rise on the 4·log2(N)+7-th rising edge after the sampling edge. That is 15 edges at N=4. The count covers 4·log2(N) reduction levels, 4 copy steps and 3 inter-cluster moves.
- R7: Once done_o is high, it stays high and max_o and min_o stay unchanged until the next accepted start, even when new values are loaded meanwhile.
- R8: start_i and load writes that arrive while a sequence is running are ignored.
- R9: Whenever done_o is high, min_o is not greater than max_o.
- R10: An accepted start clears done_o on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Write one data value this cycle |
| load_idx_i | input | IDX_W | Data element index (6 bits at N=4) |
| load_val_i | input | W | Value to store |
| start_i | input | 1 | Begin a max/min sequence |
| max_o | output | W | Maximum result |
| min_o | output | W | Minimum result |
| done_o | output | 1 | Results valid, held until next start |

## Verification
The bench builds the block at its defaults: N=4, which gives 36 data values in nine clusters, and W=8, which puts the all-ones sentinel at 255. Loaded values are kept between 1 and 254, so the zero and all-ones seeds sit just outside the data range. At this size, two reduction levels per cluster and all three transfer directions are exercised. The extreme values can be placed at the first and last load indices, and a write to the unused index range 36 to 63 can be tried as well.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RED  = 2'd1,
    ST_CPY  = 2'd2,
    ST_XFR  = 2'd3
  } mm_state_e;

  // Phase 0: max in data clusters. Phase 1: max in left column, min in data.
  // Phase 2: max in corner, min in top row. Phase 3: min in corner.
  function automatic logic pick_max(input logic [1:0] phase, input logic row0, input logic col0);
    case (phase)
      2'd0:    pick_max = 1'b1;
      2'd1:    pick_max = col0;
      2'd2:    pick_max = row0 & col0;
      default: pick_max = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mm_seq_ctrl.sv
module mm_seq_ctrl
  import mm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       idle_o,
  output logic       red_o,
  output logic       first_o,
  output logic       cpy_o,
  output logic       xfr_o,
  output logic [1:0] phase_o,
  output logic       done_o
);
  localparam int LVLS  = $clog2(N);
  localparam int LVL_W = (LVLS > 1) ? $clog2(LVLS) : 1;
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(LVLS - 1);

  mm_state_e        state_q;
  logic [1:0]       phase_q;
  logic [LVL_W-1:0] lvl_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 2'd0;
      lvl_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RED;
          phase_q <= 2'd0;
          lvl_q   <= '0;
          done_q  <= 1'b0;
        end
        ST_RED: begin
          if (lvl_q == LVL_LAST) state_q <= ST_CPY;
          else                   lvl_q   <= lvl_q + 1'b1;
        end
        ST_CPY: begin
          if (phase_q == 2'd3) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_XFR;
          end
        end
        default: begin
          state_q <= ST_RED;
          lvl_q   <= '0;
          phase_q <= phase_q + 2'd1;
        end
      endcase
    end
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign red_o   = (state_q == ST_RED);
  assign first_o = (lvl_q == '0);
  assign cpy_o   = (state_q == ST_CPY);
  assign xfr_o   = (state_q == ST_XFR);
  assign phase_o = phase_q;
  assign done_o  = done_q;

endmodule

// File: rtl/mm_reduce_lane.sv
module mm_reduce_lane #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                first_i,
  input  logic                max_i,
  input  logic [N-1:0][W-1:0] leaf_i,
  output logic [W-1:0]        res_o
);
  localparam int HALF = N / 2;
  localparam int QTR  = N / 4;

  logic [HALF-1:0][W-1:0] wrk_q, wrk_d;

  function automatic logic [W-1:0] pick(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic want_max);
    if (want_max) pick = (x > y) ? x : y;
    else          pick = (x < y) ? x : y;
  endfunction

  // One tree level per enabled cycle: leaves into the node row, then halving.
  always_comb begin
    wrk_d = wrk_q;
    if (first_i) begin
      for (int k = 0; k < HALF; k++) wrk_d[k] = pick(leaf_i[2*k], leaf_i[2*k+1], max_i);
    end else begin
      for (int k = 0; k < QTR; k++) wrk_d[k] = pick(wrk_q[2*k], wrk_q[2*k+1], max_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wrk_q <= '0;
    else if (en_i) wrk_q <= wrk_d;
  end

  assign res_o = wrk_q[0];

endmodule

// File: rtl/mm_grid_top.sv
module mm_grid_top
  import mm_pkg::*;
#(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int M     = N * (N - 1) * (N - 1),
  parameter int IDX_W = $clog2(M)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic [W-1:0]     load_val_i,
  input  logic             start_i,
  output logic [W-1:0]     max_o,
  output logic [W-1:0]     min_o,
  output logic             done_o
);
  logic       idle, red, first, cpy, xfr, seed;
  logic [1:0] phase;

  logic [N-1:0][N-1:0][N-1:0][W-1:0] a_q;
  logic [N-1:0][N-1:0][W-1:0]        b_q;
  logic [N-1:0][N-1:0][W-1:0]        res;

  mm_seq_ctrl #(.N(N)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .idle_o  (idle),
    .red_o   (red),
    .first_o (first),
    .cpy_o   (cpy),
    .xfr_o   (xfr),
    .phase_o (phase),
    .done_o  (done_o)
  );

  assign seed = idle & start_i;

  for (genvar gr = 0; gr < N; gr++) begin : g_row
    for (genvar gc = 0; gc < N; gc++) begin : g_col
      mm_reduce_lane #(.N(N), .W(W)) lane_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (red),
        .first_i (first),
        .max_i   (pick_max(phase, gr == 0, gc == 0)),
        .leaf_i  (a_q[gr][gc]),
        .res_o   (res[gr][gc])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (load_en_i && idle) begin
        for (int r = 1; r < N; r++)
          for (int c = 1; c < N; c++)
            for (int k = 0; k < N; k++)
              if (load_idx_i == IDX_W'(((r - 1) * (N - 1) + (c - 1)) * N + k))
                a_q[r][c][k] <= load_val_i;
      end
      if (seed) begin
        for (int r = 0; r < N; r++) a_q[r][0][0] <= '0;
        for (int c = 1; c < N; c++) a_q[0][c][0] <= '1;
      end
      if (cpy) begin
        case (phase)
          2'd0: for (int r = 1; r < N; r++)
                  for (int c = 1; c < N; c++) b_q[r][c] <= res[r][c];
          2'd1: for (int r = 1; r < N; r++)
                  for (int c = 0; c < N; c++) b_q[r][c] <= res[r][c];
          2'd2: begin
            a_q[0][0][0] <= res[0][0];
            for (int c = 1; c < N; c++) b_q[0][c] <= res[0][c];
          end
          default: b_q[0][0] <= res[0][0];
        endcase
      end
      if (xfr) begin
        case (phase)
          // row-wise transpose: leaf 0 of (r,c) to leaf c of (r,0)
          2'd0: for (int r = 1; r < N; r++)
                  for (int c = 1; c < N; c++) a_q[r][0][c] <= b_q[r][c];
          // column-wise transpose: leaf 0 of (r,c) to leaf r of (0,c)
          2'd1: for (int r = 1; r < N; r++)
                  for (int c = 0; c < N; c++) a_q[0][c][r] <= b_q[r][c];
          default: for (int c = 1; c < N; c++) a_q[0][0][c] <= b_q[0][c];
        endcase
      end
    end
  end

  assign max_o = a_q[0][0][0];
  assign min_o = b_q[0][0];

endmodule

// File: rtl/mm_grid_chk.sv
module mm_grid_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         done_o,
  input logic [W-1:0] max_o,
  input logic [W-1:0] min_o,
  input logic         idle_i,
  input logic         red_i,
  input logic         cpy_i,
  input logic         xfr_i
);
  localparam int STEPS = 4 * $clog2(N) + 7;

  logic [7:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i && idle_i) cnt_q <= '0;
    else if (!idle_i)           cnt_q <= cnt_q + 8'd1;
  end

  assert_min_le_max_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (min_o <= max_o));

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(max_o) && $stable(min_o)));

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cnt_q == 8'(STEPS)));

  assert_one_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({red_i, cpy_i, xfr_i}) && (idle_i == !(red_i || cpy_i || xfr_i)));

  assert_xfer_then_reduce_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfr_i |=> red_i);

  assert_restart_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && idle_i) |=> (!done_o && red_i));

  assert_busy_no_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !cpy_i) |=> !done_o);

endmodule

bind mm_grid_top mm_grid_chk #(.N(N), .W(W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .max_o   (max_o),
  .min_o   (min_o),
  .idle_i  (idle),
  .red_i   (red),
  .cpy_i   (cpy),
  .xfr_i   (xfr)
);

// File: tb/mm_grid_top_tb_top.sv
module mm_grid_top_tb_top;
  localparam int N     = 4;
  localparam int W     = 8;
  localparam int M     = N * (N - 1) * (N - 1);
  localparam int IDX_W = $clog2(M);
  localparam int LAT   = 4 * $clog2(N) + 7;

  typedef struct { int mx; int mn; } exp_t;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             load_en = 1'b0;
  logic [IDX_W-1:0] load_idx = '0;
  logic [W-1:0]     load_val = '0;
  logic             start = 1'b0;
  logic [W-1:0]     max_o, min_o;
  logic             done;

  int   n_tests = 0;
  int   n_fail  = 0;
  int   vals [M];
  exp_t sb_q [$];
  logic done_d = 1'b0;

  always #5 clk = ~clk;

  mm_grid_top #(.N(N), .W(W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .load_en_i  (load_en),
    .load_idx_i (load_idx),
    .load_val_i (load_val),
    .start_i    (start),
    .max_o      (max_o),
    .min_o      (min_o),
    .done_o     (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_one(input int idx, input int val);
    @(negedge clk);
    load_en  = 1'b1;
    load_idx = IDX_W'(idx);
    load_val = W'(val);
    @(negedge clk);
    load_en  = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < M; i++) begin
      @(negedge clk);
      load_en  = 1'b1;
      load_idx = IDX_W'(i);
      load_val = W'(vals[i]);
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Driver side of the scoreboard: reference max/min of the loaded set.
  task automatic push_exp();
    exp_t e;
    e.mx = 0;
    e.mn = 1 << W;
    for (int i = 0; i < M; i++) begin
      if (vals[i] > e.mx) e.mx = vals[i];
      if (vals[i] < e.mn) e.mn = vals[i];
    end
    sb_q.push_back(e);
  endtask

  // Pulse start, count edges until done is seen (sampling edge included).
  task automatic run(input string tag);
    int lat;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk({tag, " R10 done cleared after start"}, int'(done), 0);
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " R6 start-to-done edges"}, lat, LAT + 1);
  endtask

  // Monitor side: compare on each rising done.
  initial begin
    forever begin
      @(negedge clk);
      if (done && !done_d) begin
        if (sb_q.size() == 0) begin
          n_tests++;
          n_fail++;
          $display("[TB] FAIL R4 unexpected done actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R4 max", int'(max_o), e.mx);
          chk("R5 min", int'(min_o), e.mn);
        end
      end
      done_d = done;
    end
  end

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("[TB] FAIL watchdog expired actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hold_mx, hold_mn;
    repeat (2) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 max after reset", int'(max_o), 0);
    chk("R1 min after reset", int'(min_o), 0);
    rst_ni = 1'b1;

    // random set
    for (int i = 0; i < M; i++) vals[i] = $urandom_range(1, 254);
    load_all();
    push_exp();
    run("rand");

    // R7: loads while done leave results and done untouched
    hold_mx = int'(max_o);
    hold_mn = int'(min_o);
    vals[3] = 254;
    load_one(3, 254);
    vals[20] = 1;
    load_one(20, 1);
    repeat (3) @(negedge clk);
    chk("R7 done held", int'(done), 1);
    chk("R7 max held", int'(max_o), hold_mx);
    chk("R7 min held", int'(min_o), hold_mn);
    push_exp();
    run("after-idle-load");

    // R2: extremes at first and last index, out-of-range write ignored
    for (int i = 0; i < M; i++) vals[i] = $urandom_range(2, 253);
    vals[0]     = 254;
    vals[M - 1] = 1;
    load_all();
    load_one(M, 255);
    load_one((1 << IDX_W) - 1, 255);
    push_exp();
    run("R2 extremes");
    chk("R2 max from index 0", int'(max_o), 254);
    chk("R2 min from last index", int'(min_o), 1);

    // R3: all-equal sets, seeds must not surface
    for (int i = 0; i < M; i++) vals[i] = 77;
    load_all();
    push_exp();
    run("R3 equal mid");
    chk("R3 equal max", int'(max_o), 77);
    chk("R3 equal min", int'(min_o), 77);
    for (int i = 0; i < M; i++) vals[i] = 1;
    load_all();
    push_exp();
    run("R3 equal low");
    chk("R3 low min not zero seed", int'(min_o), 1);
    for (int i = 0; i < M; i++) vals[i] = 254;
    load_all();
    push_exp();
    run("R3 equal high");
    chk("R3 high max not all-ones seed", int'(max_o), 254);

    // ascending and descending ramps
    for (int i = 0; i < M; i++) vals[i] = i + 1;
    load_all();
    push_exp();
    run("ramp up");
    for (int i = 0; i < M; i++) vals[i] = 250 - 6 * i;
    load_all();
    push_exp();
    run("ramp down");

    // R8: restart and load while busy are ignored
    for (int i = 0; i < M; i++) vals[i] = $urandom_range(10, 200);
    load_all();
    push_exp();
    begin
      int lat;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      repeat (4) begin
        @(negedge clk);
        lat++;
      end
      start    = 1'b1;
      load_en  = 1'b1;
      load_idx = '0;
      load_val = 8'd255;
      @(negedge clk);
      lat++;
      start   = 1'b0;
      load_en = 1'b0;
      while (!done && lat < 200) begin
        @(negedge clk);
        lat++;
      end
      chk("R8 latency unaffected by busy start", lat, LAT + 1);
    end
    push_exp();
    run("R8 rerun without reload");
    chk("R8 busy load not stored", int'(max_o != 8'd255), 1);

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", sb_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule